// File: doc/BRIEF.md
# Serialized Power Request Bridge

This block is a small register window between a host bus and a power-management microcontroller. The host uses it to ask for a new performance level on one of two clusters, or to run a configuration read or write that carries a function number and a device field. All of these requests go down one shared channel to the microcontroller, and only one request may be in flight at a time.

The host writes a per-cluster level register, or loads the write-data register and then writes a command word with its start bit set. The bridge presents the request on a valid/ready port and then waits for a single-cycle response that reports ok or error. The outcome is recorded in a status register that holds one nibble per request type. A level-high interrupt stays up until the host reads status, and that read clears it. Results of configuration reads appear in a read-data register.

Register word offsets are 0 for the cluster-0 level, 1 for the cluster-1 level, 2 for the command word, 3 for write data, 4 for read data and 5 for status.

Top module: `pwrb_bridge`

## Requirements
- R1: After reset, status reads 0, irq is low, both level registers read 0, read data reads 0 and no request is presented.
- R2: A read of the level register at offset c (c = 0 or 1) returns the current level of that cluster at once. A write there presents a request of type c with write flag 1, function 0, device 0 and data equal to write-data bits 2:0 (a level from 0 to 7). The stored level takes the new value only after an ok response.
- R3: A command word with bit 31 set presents a request of type 2, with write flag taken from bit 30, function from bits 25:20 and device from bits 11:0. Its data is the write-data register as loaded before the command.
- R4: A command word with bit 31 clear presents no request and leaves status and irq unchanged.
- R5: Exactly one request is presented per accepted launch. A level or start-command write that arrives while a request is pending is dropped and sets sticky status bit 12. Status bit 13 reads 1 while a request is pending.
- R6: A response sets, for the pending type t, status bit 4t on ok or bit 4t+1 on error.
- R7: An ok response to a configuration read loads its data into the read-data register, no later than the complete bit appears.
- R8: An error response leaves read data and the cluster level unchanged.
- R9: irq is high while any complete or error bit is set. A status read returns the bits and clears them, and irq is low in the following cycle.
- R10: While a request is presented and not accepted, the request valid and all request fields stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hb_sel | input | 1 | Host access strobe, one cycle per access |
| hb_wr | input | 1 | 1 = write, 0 = read |
| hb_addr | input | 3 | Register word offset |
| hb_wdata | input | 32 | Host write data |
| hb_rdata | output | 32 | Host read data, valid in the access cycle |
| irq | output | 1 | Level-high completion interrupt |
| mc_valid | output | 1 | Request valid toward microcontroller |
| mc_ready | input | 1 | Request accepted |
| mc_type | output | 2 | Request type: 0/1 cluster level, 2 configuration |
| mc_write | output | 1 | Request write flag |
| mc_func | output | 6 | Configuration function number |
| mc_dev | output | 12 | Configuration device/offset field |
| mc_data | output | 32 | Request data |
| rs_valid | input | 1 | Response strobe, one cycle |
| rs_err | input | 1 | Response is an error |
| rs_data | input | 32 | Response read data |

## Verification
Random level writes, configuration reads and configuration writes are mixed with random acceptance delays, response latencies and error responses. This separates the correct routing of each type to its own status nibble from an error that is reported in the wrong bit, and it shows that error responses leave the level and read-data registers unchanged. Directed cases cover a command without its start bit and writes that arrive while a request is pending, where the only observable effects should be the sticky drop flag and the pending flag. A back-to-back pair of status reads shows that a read both clears status and lowers irq.

// File: rtl/pwrb_pkg.sv
package pwrb_pkg;
  // command word layout is fixed by the microcontroller side
  localparam int WORD_W       = 32;
  localparam int FUNC_W       = 6;
  localparam int DEV_W        = 12;
  localparam int CMD_GO_BIT   = 31;
  localparam int CMD_WR_BIT   = 30;
  localparam int CMD_FUNC_LSB = 20;
  localparam int NIB_W        = 4;

  function automatic logic cmd_go(input logic [WORD_W-1:0] w);
    return logic'(w >> CMD_GO_BIT);
  endfunction

  function automatic logic cmd_wr(input logic [WORD_W-1:0] w);
    return logic'(w >> CMD_WR_BIT);
  endfunction

  function automatic logic [FUNC_W-1:0] cmd_func(input logic [WORD_W-1:0] w);
    return FUNC_W'(w >> CMD_FUNC_LSB);
  endfunction

  function automatic logic [DEV_W-1:0] cmd_dev(input logic [WORD_W-1:0] w);
    return DEV_W'(w);
  endfunction

  // status bit positions per request type
  function automatic int done_pos(input int t);
    return t * NIB_W;
  endfunction

  function automatic int err_pos(input int t);
    return t * NIB_W + 1;
  endfunction
endpackage

// File: rtl/pwrb_regs.sv
module pwrb_regs
  import pwrb_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int LVL_W  = 3,
  parameter int NCLUST = 2,
  parameter int TYPE_W = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  hb_sel,
  input  logic                  hb_wr,
  input  logic [ADDR_W-1:0]     hb_addr,
  input  logic [WORD_W-1:0]     hb_wdata,
  output logic [WORD_W-1:0]     hb_rdata,
  input  logic                  busy,
  input  logic [NCLUST-1:0]     lvl_commit,
  input  logic [LVL_W-1:0]      commit_lvl,
  input  logic                  rd_capture,
  input  logic [WORD_W-1:0]     rd_value,
  input  logic [WORD_W-1:0]     status_word,
  output logic                  launch_vld,
  output logic [TYPE_W-1:0]     l_kind,
  output logic                  l_wr,
  output logic [FUNC_W-1:0]     l_func,
  output logic [DEV_W-1:0]      l_dev,
  output logic [WORD_W-1:0]     l_data,
  output logic                  drop_evt,
  output logic                  stat_rd,
  output logic [WORD_W-1:0]     rd_hold
);
  // register offsets follow the cluster level registers
  localparam int OFS_CMD  = NCLUST;
  localparam int OFS_WDAT = NCLUST + 1;
  localparam int OFS_RDAT = NCLUST + 2;
  localparam int OFS_STAT = NCLUST + 3;

  logic wr_evt, rd_evt;
  logic cmd_hit, cmd_launch, attempt;
  logic [NCLUST-1:0] perf_hit;
  logic [NCLUST*LVL_W-1:0] lvl_all;
  logic [WORD_W-1:0] cmd_q, wdat_q, rd_q;

  assign wr_evt = hb_sel & hb_wr;
  assign rd_evt = hb_sel & ~hb_wr;

  for (genvar c = 0; c < NCLUST; c++) begin : g_clu
    logic [LVL_W-1:0] lvl_r;
    assign perf_hit[c] = wr_evt && (hb_addr == ADDR_W'(c));
    always_ff @(posedge clk) begin
      if (!rst_n)             lvl_r <= '0;
      else if (lvl_commit[c]) lvl_r <= commit_lvl;
    end
    assign lvl_all[c*LVL_W +: LVL_W] = lvl_r;
  end

  assign cmd_hit    = wr_evt && (hb_addr == ADDR_W'(OFS_CMD));
  assign cmd_launch = cmd_hit && cmd_go(hb_wdata);
  assign attempt    = (|perf_hit) | cmd_launch;
  assign launch_vld = attempt & ~busy;
  assign drop_evt   = attempt & busy;
  assign stat_rd    = rd_evt && (hb_addr == ADDR_W'(OFS_STAT));
  assign rd_hold    = rd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      wdat_q <= '0;
      rd_q   <= '0;
    end else begin
      if (cmd_hit && !(cmd_launch && busy)) cmd_q <= hb_wdata;
      if (wr_evt && (hb_addr == ADDR_W'(OFS_WDAT))) wdat_q <= hb_wdata;
      if (rd_capture) rd_q <= rd_value;
    end
  end

  // request fields handed to the channel in the launch cycle
  always_comb begin
    l_kind = TYPE_W'(NCLUST);
    l_wr   = cmd_wr(hb_wdata);
    l_func = cmd_func(hb_wdata);
    l_dev  = cmd_dev(hb_wdata);
    l_data = wdat_q;
    for (int c = 0; c < NCLUST; c++) begin
      if (perf_hit[c]) begin
        l_kind = TYPE_W'(c);
        l_wr   = 1'b1;
        l_func = '0;
        l_dev  = '0;
        l_data = WORD_W'(hb_wdata[LVL_W-1:0]);
      end
    end
  end

  always_comb begin
    hb_rdata = '0;
    for (int c = 0; c < NCLUST; c++) begin
      if (hb_addr == ADDR_W'(c)) hb_rdata = WORD_W'(lvl_all[c*LVL_W +: LVL_W]);
    end
    if (hb_addr == ADDR_W'(OFS_CMD))  hb_rdata = cmd_q;
    if (hb_addr == ADDR_W'(OFS_WDAT)) hb_rdata = wdat_q;
    if (hb_addr == ADDR_W'(OFS_RDAT)) hb_rdata = rd_q;
    if (hb_addr == ADDR_W'(OFS_STAT)) hb_rdata = status_word;
  end
endmodule

// File: rtl/pwrb_chan.sv
module pwrb_chan
  import pwrb_pkg::*;
#(
  parameter int LVL_W  = 3,
  parameter int NCLUST = 2,
  parameter int TYPE_W = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  launch_vld,
  input  logic [TYPE_W-1:0]     l_kind,
  input  logic                  l_wr,
  input  logic [FUNC_W-1:0]     l_func,
  input  logic [DEV_W-1:0]      l_dev,
  input  logic [WORD_W-1:0]     l_data,
  output logic                  mc_valid,
  input  logic                  mc_ready,
  output logic [TYPE_W-1:0]     mc_type,
  output logic                  mc_write,
  output logic [FUNC_W-1:0]     mc_func,
  output logic [DEV_W-1:0]      mc_dev,
  output logic [WORD_W-1:0]     mc_data,
  input  logic                  rs_valid,
  input  logic                  rs_err,
  input  logic [WORD_W-1:0]     rs_data,
  output logic                  busy,
  output logic                  rsp_take,
  output logic                  fin_ok,
  output logic                  fin_err,
  output logic [TYPE_W-1:0]     fin_type,
  output logic                  rd_capture,
  output logic [WORD_W-1:0]     rd_value,
  output logic [NCLUST-1:0]     lvl_commit,
  output logic [LVL_W-1:0]      commit_lvl
);
  typedef enum logic [1:0] {CH_IDLE, CH_SEND, CH_WAIT} ch_state_e;

  ch_state_e          st;
  logic [TYPE_W-1:0]  q_kind;
  logic               q_wr;
  logic [FUNC_W-1:0]  q_func;
  logic [DEV_W-1:0]   q_dev;
  logic [WORD_W-1:0]  q_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= CH_IDLE;
      q_kind <= '0;
      q_wr   <= 1'b0;
      q_func <= '0;
      q_dev  <= '0;
      q_data <= '0;
    end else begin
      unique case (st)
        CH_IDLE: if (launch_vld) begin
          st     <= CH_SEND;
          q_kind <= l_kind;
          q_wr   <= l_wr;
          q_func <= l_func;
          q_dev  <= l_dev;
          q_data <= l_data;
        end
        CH_SEND: if (mc_ready) st <= CH_WAIT;
        CH_WAIT: if (rs_valid) st <= CH_IDLE;
        default: st <= CH_IDLE;
      endcase
    end
  end

  assign busy     = (st != CH_IDLE);
  assign mc_valid = (st == CH_SEND);
  assign mc_type  = q_kind;
  assign mc_write = q_wr;
  assign mc_func  = q_func;
  assign mc_dev   = q_dev;
  assign mc_data  = q_data;

  assign rsp_take   = (st == CH_WAIT) && rs_valid;
  assign fin_ok     = rsp_take && !rs_err;
  assign fin_err    = rsp_take && rs_err;
  assign fin_type   = q_kind;
  assign rd_capture = fin_ok && (q_kind == TYPE_W'(NCLUST)) && !q_wr;
  assign rd_value   = rs_data;
  assign commit_lvl = q_data[LVL_W-1:0];

  for (genvar c = 0; c < NCLUST; c++) begin : g_commit
    assign lvl_commit[c] = fin_ok && (q_kind == TYPE_W'(c));
  end
endmodule

// File: rtl/pwrb_status.sv
module pwrb_status
  import pwrb_pkg::*;
#(
  parameter int NTYPES = 3,
  parameter int TYPE_W = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fin_ok,
  input  logic                  fin_err,
  input  logic [TYPE_W-1:0]     fin_type,
  input  logic                  drop_evt,
  input  logic                  stat_rd,
  input  logic                  busy,
  output logic [WORD_W-1:0]     status_word,
  output logic                  irq
);
  localparam int DROP_POS = NTYPES * NIB_W;
  localparam int PEND_POS = DROP_POS + 1;

  logic [NTYPES-1:0] done_v, err_v;
  logic              drop_q;

  // new events win over a clearing read in the same cycle
  for (genvar t = 0; t < NTYPES; t++) begin : g_nib
    logic done_r, err_r;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        done_r <= 1'b0;
        err_r  <= 1'b0;
      end else begin
        done_r <= (done_r & ~stat_rd) | (fin_ok  && fin_type == TYPE_W'(t));
        err_r  <= (err_r  & ~stat_rd) | (fin_err && fin_type == TYPE_W'(t));
      end
    end
    assign done_v[t] = done_r;
    assign err_v[t]  = err_r;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) drop_q <= 1'b0;
    else        drop_q <= (drop_q & ~stat_rd) | drop_evt;
  end

  always_comb begin
    status_word = '0;
    for (int t = 0; t < NTYPES; t++) begin
      status_word[done_pos(t)] = done_v[t];
      status_word[err_pos(t)]  = err_v[t];
    end
    status_word[DROP_POS] = drop_q;
    status_word[PEND_POS] = busy;
  end

  assign irq = (|done_v) | (|err_v);
endmodule

// File: rtl/pwrb_bridge.sv
module pwrb_bridge
  import pwrb_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int LVL_W  = 3,
  parameter int NCLUST = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  hb_sel,
  input  logic                  hb_wr,
  input  logic [ADDR_W-1:0]     hb_addr,
  input  logic [31:0]           hb_wdata,
  output logic [31:0]           hb_rdata,
  output logic                  irq,
  output logic                  mc_valid,
  input  logic                  mc_ready,
  output logic [$clog2(NCLUST+2)-1:0] mc_type,
  output logic                  mc_write,
  output logic [5:0]            mc_func,
  output logic [11:0]           mc_dev,
  output logic [31:0]           mc_data,
  input  logic                  rs_valid,
  input  logic                  rs_err,
  input  logic [31:0]           rs_data
);
  localparam int NTYPES = NCLUST + 1;
  localparam int TYPE_W = $clog2(NTYPES + 1);

  // named internal events, also observed by the checker
  logic                  chan_busy, rsp_take, stat_rd, drop_evt;
  logic                  launch_vld, l_wr, fin_ok, fin_err, rd_capture;
  logic [TYPE_W-1:0]     l_kind, fin_type;
  logic [FUNC_W-1:0]     l_func;
  logic [DEV_W-1:0]      l_dev;
  logic [WORD_W-1:0]     l_data, rd_value, status_word, rd_q;
  logic [NCLUST-1:0]     lvl_commit;
  logic [LVL_W-1:0]      commit_lvl;

  pwrb_regs #(.ADDR_W(ADDR_W), .LVL_W(LVL_W), .NCLUST(NCLUST), .TYPE_W(TYPE_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .hb_sel(hb_sel), .hb_wr(hb_wr), .hb_addr(hb_addr), .hb_wdata(hb_wdata),
    .hb_rdata(hb_rdata), .busy(chan_busy),
    .lvl_commit(lvl_commit), .commit_lvl(commit_lvl),
    .rd_capture(rd_capture), .rd_value(rd_value), .status_word(status_word),
    .launch_vld(launch_vld), .l_kind(l_kind), .l_wr(l_wr), .l_func(l_func),
    .l_dev(l_dev), .l_data(l_data), .drop_evt(drop_evt), .stat_rd(stat_rd),
    .rd_hold(rd_q)
  );

  pwrb_chan #(.LVL_W(LVL_W), .NCLUST(NCLUST), .TYPE_W(TYPE_W)) u_chan (
    .clk(clk), .rst_n(rst_n),
    .launch_vld(launch_vld), .l_kind(l_kind), .l_wr(l_wr), .l_func(l_func),
    .l_dev(l_dev), .l_data(l_data),
    .mc_valid(mc_valid), .mc_ready(mc_ready), .mc_type(mc_type),
    .mc_write(mc_write), .mc_func(mc_func), .mc_dev(mc_dev), .mc_data(mc_data),
    .rs_valid(rs_valid), .rs_err(rs_err), .rs_data(rs_data),
    .busy(chan_busy), .rsp_take(rsp_take), .fin_ok(fin_ok), .fin_err(fin_err),
    .fin_type(fin_type), .rd_capture(rd_capture), .rd_value(rd_value),
    .lvl_commit(lvl_commit), .commit_lvl(commit_lvl)
  );

  pwrb_status #(.NTYPES(NTYPES), .TYPE_W(TYPE_W)) u_stat (
    .clk(clk), .rst_n(rst_n),
    .fin_ok(fin_ok), .fin_err(fin_err), .fin_type(fin_type),
    .drop_evt(drop_evt), .stat_rd(stat_rd), .busy(chan_busy),
    .status_word(status_word), .irq(irq)
  );
endmodule

// File: rtl/pwrb_bridge_chk.sv
module pwrb_bridge_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mc_valid,
  input logic        mc_ready,
  input logic [1:0]  mc_type,
  input logic        mc_write,
  input logic [5:0]  mc_func,
  input logic [11:0] mc_dev,
  input logic [31:0] mc_data,
  input logic        chan_busy,
  input logic        rsp_take,
  input logic        rs_err,
  input logic        stat_rd,
  input logic        irq,
  input logic [31:0] rd_q
);
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mc_valid && !mc_ready) |=> (mc_valid && $stable(mc_type) && $stable(mc_write)
      && $stable(mc_func) && $stable(mc_dev) && $stable(mc_data)));

  p_launch_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mc_valid) |-> !$past(chan_busy));

  p_resp_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_take |=> irq);

  p_read_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !rsp_take) |=> !irq);

  p_err_keeps_rdata_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_take && rs_err) |=> $stable(rd_q));
endmodule

bind pwrb_bridge pwrb_bridge_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .mc_valid(mc_valid), .mc_ready(mc_ready), .mc_type(mc_type),
  .mc_write(mc_write), .mc_func(mc_func), .mc_dev(mc_dev), .mc_data(mc_data),
  .chan_busy(chan_busy), .rsp_take(rsp_take), .rs_err(rs_err),
  .stat_rd(stat_rd), .irq(irq), .rd_q(rd_q)
);

// File: tb/sim_pwrb_bridge.sv
module sim_pwrb_bridge;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] A_LVL0 = 3'd0, A_LVL1 = 3'd1, A_CMD = 3'd2,
                         A_WDAT = 3'd3, A_RDAT = 3'd4, A_STAT = 3'd5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hb_sel = 1'b0, hb_wr = 1'b0;
  logic [2:0]  hb_addr = '0;
  logic [31:0] hb_wdata = '0;
  logic [31:0] hb_rdata;
  logic        irq, mc_valid, mc_write;
  logic        mc_ready = 1'b0;
  logic [1:0]  mc_type;
  logic [5:0]  mc_func;
  logic [11:0] mc_dev;
  logic [31:0] mc_data;
  logic        rs_valid = 1'b0, rs_err = 1'b0;
  logic [31:0] rs_data = '0;

  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;

  // stub controls and captures
  int          st_rdy_dly = 0, st_lat = 0;
  bit          st_err = 1'b0;
  logic [31:0] st_rdata = '0;
  int          req_count = 0;
  bit          hold_ok = 1'b1;
  logic [1:0]  cap_type;
  logic        cap_write;
  logic [5:0]  cap_func;
  logic [11:0] cap_dev;
  logic [31:0] cap_data;

  logic [2:0]  exp_lvl [2];
  logic [31:0] exp_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwrb_bridge u0 (
    .clk(clk), .rst_n(rst_n), .hb_sel(hb_sel), .hb_wr(hb_wr), .hb_addr(hb_addr),
    .hb_wdata(hb_wdata), .hb_rdata(hb_rdata), .irq(irq),
    .mc_valid(mc_valid), .mc_ready(mc_ready), .mc_type(mc_type),
    .mc_write(mc_write), .mc_func(mc_func), .mc_dev(mc_dev), .mc_data(mc_data),
    .rs_valid(rs_valid), .rs_err(rs_err), .rs_data(rs_data)
  );

  function automatic logic [31:0] mk_cmd(input bit go, input bit wr,
                                         input logic [5:0] f, input logic [11:0] d);
    logic [31:0] w;
    w = 32'h0;
    w[31] = go;
    w[30] = wr;
    w[25:20] = f;
    w[11:0] = d;
    return w;
  endfunction

  function automatic logic [31:0] exp_status(input int t, input bit err);
    return err ? (32'h1 << (t*4 + 1)) : (32'h1 << (t*4));
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    hb_sel = 1'b1; hb_wr = 1'b1; hb_addr = a; hb_wdata = d;
    @(negedge clk);
    hb_sel = 1'b0; hb_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    hb_sel = 1'b1; hb_wr = 1'b0; hb_addr = a;
    #1 d = hb_rdata;
    @(negedge clk);
    hb_sel = 1'b0;
  endtask

  task automatic wait_irq();
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (irq) break;
    end
  endtask

  // behavioural microcontroller stub
  initial begin
    forever begin
      @(negedge clk);
      if (mc_valid) begin
        hold_ok = 1'b1;
        for (int i = 0; i < st_rdy_dly; i++) begin
          @(negedge clk);
          if (!mc_valid) hold_ok = 1'b0;
        end
        cap_type = mc_type; cap_write = mc_write; cap_func = mc_func;
        cap_dev = mc_dev; cap_data = mc_data;
        req_count++;
        mc_ready = 1'b1;
        @(negedge clk);
        mc_ready = 1'b0;
        for (int i = 0; i < st_lat; i++) @(negedge clk);
        rs_valid = 1'b1; rs_err = st_err; rs_data = st_rdata;
        @(negedge clk);
        rs_valid = 1'b0; rs_err = 1'b0;
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  task automatic do_txn();
    logic [31:0] rd;
    int kind, cnt0;
    bit err, wr;
    logic [2:0] lvl;
    logic [5:0] fn;
    logic [11:0] dv;
    logic [31:0] wd;
    kind = $urandom % 3;
    err = ($urandom % 4) == 0;
    st_rdy_dly = $urandom % 4;
    st_lat = $urandom % 5;
    st_err = err;
    st_rdata = $urandom;
    cnt0 = req_count;
    if (kind < 2) begin
      lvl = 3'($urandom % 8);
      bus_wr(3'(kind), {$urandom, 3'b000} | 32'(lvl));
      wait_irq();
      chk("R5 one request", 32'(req_count), 32'(cnt0 + 1));
      chk("R2 type", 32'(cap_type), 32'(kind));
      chk("R2 write flag", 32'(cap_write), 32'h1);
      chk("R2 data", cap_data, 32'(lvl));
      chk("R2 func/dev", {cap_func, cap_dev}, 32'h0);
      if (!err) exp_lvl[kind] = lvl;
    end else begin
      wr = $urandom % 2;
      fn = 6'($urandom);
      dv = 12'($urandom);
      wd = $urandom;
      bus_wr(A_WDAT, wd);
      bus_wr(A_CMD, mk_cmd(1'b1, wr, fn, dv));
      wait_irq();
      chk("R5 one request", 32'(req_count), 32'(cnt0 + 1));
      chk("R3 type", 32'(cap_type), 32'd2);
      chk("R3 write flag", 32'(cap_write), 32'(wr));
      chk("R3 func", 32'(cap_func), 32'(fn));
      chk("R3 dev", 32'(cap_dev), 32'(dv));
      chk("R3 data", cap_data, wd);
      if (!wr && !err) exp_rdata = st_rdata;
    end
    chk("R10 valid held", 32'(hold_ok), 32'h1);
    chk("R9 irq raised", 32'(irq), 32'h1);
    bus_rd(A_STAT, rd);
    chk("R6 status", rd, exp_status(kind, err));
    chk("R9 irq cleared", 32'(irq), 32'h0);
    bus_rd(A_LVL0, rd);
    chk("R2/R8 level0", rd, 32'(exp_lvl[0]));
    bus_rd(A_LVL1, rd);
    chk("R2/R8 level1", rd, 32'(exp_lvl[1]));
    bus_rd(A_RDAT, rd);
    chk("R7/R8 read data", rd, exp_rdata);
  endtask

  initial begin
    logic [31:0] rd;
    int cnt0;
    void'($urandom(32'd4242));
    exp_lvl[0] = '0; exp_lvl[1] = '0; exp_rdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 irq", 32'(irq), 32'h0);
    chk("R1 valid", 32'(mc_valid), 32'h0);
    bus_rd(A_STAT, rd);  chk("R1 status", rd, 32'h0);
    bus_rd(A_LVL0, rd);  chk("R1 level0", rd, 32'h0);
    bus_rd(A_LVL1, rd);  chk("R1 level1", rd, 32'h0);
    bus_rd(A_RDAT, rd);  chk("R1 read data", rd, 32'h0);

    // R4 command without start bit
    cnt0 = req_count;
    bus_wr(A_CMD, mk_cmd(1'b0, 1'b1, 6'h2a, 12'h155));
    repeat (10) @(negedge clk);
    chk("R4 no request", 32'(req_count), 32'(cnt0));
    chk("R4 irq low", 32'(irq), 32'h0);
    bus_rd(A_STAT, rd);  chk("R4 status", rd, 32'h0);

    // R5 writes while pending are dropped
    st_rdy_dly = 1; st_lat = 25; st_err = 1'b0; st_rdata = 32'hdead_beef;
    cnt0 = req_count;
    bus_wr(A_LVL0, 32'd5);
    bus_wr(A_LVL1, 32'd6);
    bus_wr(A_CMD, mk_cmd(1'b1, 1'b0, 6'h01, 12'h003));
    chk("R5 irq low while pending", 32'(irq), 32'h0);
    bus_rd(A_STAT, rd);
    chk("R5 drop and pending bits", rd, (32'h1 << 12) | (32'h1 << 13));
    wait_irq();
    chk("R5 single request", 32'(req_count), 32'(cnt0 + 1));
    bus_rd(A_STAT, rd);
    chk("R6 cluster0 ok", rd, 32'h1);
    bus_rd(A_STAT, rd);
    chk("R9 second read empty", rd, 32'h0);
    exp_lvl[0] = 3'd5;
    bus_rd(A_LVL0, rd);  chk("R2 level0 committed", rd, 32'd5);
    bus_rd(A_LVL1, rd);  chk("R5 level1 untouched", rd, 32'd0);

    // mixed random traffic
    for (int n = 0; n < 60; n++) do_txn();

    finish_run();
  end
endmodule